// File: doc/BRIEF.md
# Lookup-Table Logic Cell

This block is one programmable logic cell of a reconfigurable fabric. Two 16-entry lookup tables, held in writable storage, give the cell its function. A serial configuration port loads the cell. Once loaded, the cell runs in one of four modes. In the first, it gives two unrelated 4-input functions. In the second, it gives one 5-input function. In the third, it is a 1-bit arithmetic slice with a dedicated carry path. In the fourth, the tables act as a 16x2 user memory.

Each of the two outputs can take its value straight from the logic or from an output flop. Configuration chooses which, for each output. Both flops share one clock enable and one synchronous clear. Carry-in and carry-out ports let adjacent cells form a ripple chain that does not pass through general routing.

Top module: `lut_clb`

## Requirements
- R1: In mode 2'b00 (dual), fOut = tableF[fIn] and gOut = tableG[gIn], where table bit index equals the 4-bit address.
- R2: In mode 2'b01 (wide), fOut = eIn ? tableG[fIn] : tableF[fIn] and gOut is 0.
- R3: In mode 2'b10 (arith), with p = tableF[fIn] and k = tableG[fIn], cOut = p ? cIn : k, fOut = p XOR cIn and gOut = cOut.
- R4: In every mode other than arith, cOut equals cIn.
- R5: In mode 2'b11 (RAM), a clock edge with ramWe high writes wrDataF to tableF[fIn] and wrDataG to tableG[fIn]. The outputs read tableF[fIn] and tableG[fIn] combinationally, so the new value appears only after that edge.
- R6: ramWe has no effect on the tables in any mode other than RAM.
- R7: While cfgEn is high, each clock edge shifts cfgDin into a 36-bit word, most significant bit first. The word is laid out as [35:34] mode, [33] register enable for fOut, [32] register enable for gOut, [31:16] tableF and [15:0] tableG.
- R8: ramWe is ignored while cfgEn is high, even in RAM mode.
- R9: When an output's register enable is 1, that output shows the value captured at the last clock edge with regCe high, not the live logic value.
- R10: regRst clears both output flops at the next clock edge and takes precedence over regCe.
- R11: With regCe and regRst both low, both output flops hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration, RAM writes and output flops |
| cfgEn | input | 1 | Configuration shift enable |
| cfgDin | input | 1 | Serial configuration data, MSB first |
| fIn | input | 4 | Address of table F; also the address for wide, arith and RAM modes |
| gIn | input | 4 | Address of table G in dual mode |
| eIn | input | 1 | Fifth input, selects the table in wide mode |
| cIn | input | 1 | Carry in from the previous cell |
| cOut | output | 1 | Carry out to the next cell |
| ramWe | input | 1 | User write enable, RAM mode |
| wrDataF | input | 1 | Write data for table F |
| wrDataG | input | 1 | Write data for table G |
| regCe | input | 1 | Shared clock enable of the output flops |
| regRst | input | 1 | Shared synchronous clear of the output flops |
| fOut | output | 1 | First output |
| gOut | output | 1 | Second output |

## Verification
The assertions assume that the mode does not change while a user write is pending. They also assume that cfgEn is the only way the tables change, apart from a RAM-mode write. The stimulus holds cfgEn low for the whole of each functional scenario. It starts a scenario only after a full 36-bit load has completed. The single exception is a load with ramWe held high, which exercises the write block during configuration. The flop properties hold from the first edge. The table properties hold no matter what the storage contains.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int LUT_ADDR_W = 4;
  localparam int MODE_W     = 2;

  typedef enum logic [1:0] {
    MODE_DUAL  = 2'b00,
    MODE_WIDE  = 2'b01,
    MODE_ARITH = 2'b10,
    MODE_RAM   = 2'b11
  } clbMode_t;

  // decoded strobes from configuration control to datapath
  typedef struct packed {
    logic isDual;
    logic isWide;
    logic isArith;
    logic isRam;
    logic regEnF;
    logic regEnG;
  } clbStrobe_t;
endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
  parameter int ADDR_W = clb_pkg::LUT_ADDR_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0]  table_i,
  input  logic [ADDR_W-1:0] addr,
  output logic              bitOut
);
  assign bitOut = table_i[addr];
endmodule

// File: rtl/clb_cfg_ctrl.sv
module clb_cfg_ctrl
  import clb_pkg::*;
#(
  parameter int ADDR_W = LUT_ADDR_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int CFG_W = 2 * DEPTH + MODE_W + 2
) (
  input  logic              clk,
  input  logic              cfgEn,
  input  logic              cfgDin,
  input  logic              ramWe,
  input  logic [ADDR_W-1:0] ramAddr,
  input  logic              wrDataF,
  input  logic              wrDataG,
  output clbStrobe_t        strobe,
  output logic [DEPTH-1:0]  tblF,
  output logic [DEPTH-1:0]  tblG
);
  logic [MODE_W-1:0] modeReg;
  logic              regEnFReg;
  logic              regEnGReg;
  logic [DEPTH-1:0]  tblFReg;
  logic [DEPTH-1:0]  tblGReg;
  logic [CFG_W-1:0]  chainNow;
  logic              userWrite;

  assign chainNow  = {modeReg, regEnFReg, regEnGReg, tblFReg, tblGReg};
  assign userWrite = ramWe && !cfgEn && (modeReg == MODE_RAM);

  always_ff @(posedge clk) begin
    if (cfgEn) begin
      {modeReg, regEnFReg, regEnGReg, tblFReg, tblGReg} <= {chainNow[CFG_W-2:0], cfgDin};
    end else if (userWrite) begin
      tblFReg[ramAddr] <= wrDataF;
      tblGReg[ramAddr] <= wrDataG;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.isDual  = (modeReg == MODE_DUAL);
    strobe.isWide  = (modeReg == MODE_WIDE);
    strobe.isArith = (modeReg == MODE_ARITH);
    strobe.isRam   = (modeReg == MODE_RAM);
    strobe.regEnF  = regEnFReg;
    strobe.regEnG  = regEnGReg;
  end

  assign tblF = tblFReg;
  assign tblG = tblGReg;
endmodule

// File: rtl/clb_datapath.sv
module clb_datapath
  import clb_pkg::*;
#(
  parameter int ADDR_W = LUT_ADDR_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int LANES = 2
) (
  input  logic              clk,
  input  clbStrobe_t        strobe,
  input  logic [DEPTH-1:0]  tblF,
  input  logic [DEPTH-1:0]  tblG,
  input  logic [ADDR_W-1:0] fIn,
  input  logic [ADDR_W-1:0] gIn,
  input  logic              eIn,
  input  logic              cIn,
  input  logic              regCe,
  input  logic              regRst,
  output logic              fComb,
  output logic              gComb,
  output logic              fQ,
  output logic              gQ,
  output logic              cOut
);
  logic [ADDR_W-1:0] laneAddr [LANES];
  logic [DEPTH-1:0]  laneTbl  [LANES];
  logic              laneBit  [LANES];
  logic              propBit;
  logic              genBit;
  logic              carryBit;

  assign laneTbl[0]  = tblF;
  assign laneTbl[1]  = tblG;
  assign laneAddr[0] = fIn;
  assign laneAddr[1] = strobe.isDual ? gIn : fIn;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    clb_lut #(.ADDR_W(ADDR_W)) u_lut (
      .table_i(laneTbl[lane]),
      .addr   (laneAddr[lane]),
      .bitOut (laneBit[lane])
    );
  end

  assign propBit  = laneBit[0];
  assign genBit   = laneBit[1];
  assign carryBit = strobe.isArith ? (propBit ? cIn : genBit) : cIn;
  assign cOut     = carryBit;

  always_comb begin
    fComb = propBit;
    gComb = genBit;
    if (strobe.isWide) begin
      fComb = eIn ? genBit : propBit;
      gComb = 1'b0;
    end else if (strobe.isArith) begin
      fComb = propBit ^ cIn;
      gComb = carryBit;
    end
  end

  always_ff @(posedge clk) begin
    if (regRst) begin
      fQ <= 1'b0;
      gQ <= 1'b0;
    end else if (regCe) begin
      fQ <= fComb;
      gQ <= gComb;
    end
  end
endmodule

// File: rtl/lut_clb.sv
module lut_clb
  import clb_pkg::*;
#(
  parameter int ADDR_W = LUT_ADDR_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              cfgEn,
  input  logic              cfgDin,
  input  logic [ADDR_W-1:0] fIn,
  input  logic [ADDR_W-1:0] gIn,
  input  logic              eIn,
  input  logic              cIn,
  output logic              cOut,
  input  logic              ramWe,
  input  logic              wrDataF,
  input  logic              wrDataG,
  input  logic              regCe,
  input  logic              regRst,
  output logic              fOut,
  output logic              gOut
);
  clbStrobe_t       strobe;
  logic [DEPTH-1:0] tblF;
  logic [DEPTH-1:0] tblG;
  logic             fComb;
  logic             gComb;
  logic             fQ;
  logic             gQ;

  clb_cfg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .cfgEn  (cfgEn),
    .cfgDin (cfgDin),
    .ramWe  (ramWe),
    .ramAddr(fIn),
    .wrDataF(wrDataF),
    .wrDataG(wrDataG),
    .strobe (strobe),
    .tblF   (tblF),
    .tblG   (tblG)
  );

  clb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk   (clk),
    .strobe(strobe),
    .tblF  (tblF),
    .tblG  (tblG),
    .fIn   (fIn),
    .gIn   (gIn),
    .eIn   (eIn),
    .cIn   (cIn),
    .regCe (regCe),
    .regRst(regRst),
    .fComb (fComb),
    .gComb (gComb),
    .fQ    (fQ),
    .gQ    (gQ),
    .cOut  (cOut)
  );

  assign fOut = strobe.regEnF ? fQ : fComb;
  assign gOut = strobe.regEnG ? gQ : gComb;
endmodule

// File: rtl/clb_chk.sv
module clb_chk
  import clb_pkg::*;
#(
  parameter int ADDR_W = LUT_ADDR_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              cfgEn,
  input logic              ramWe,
  input logic              regCe,
  input logic              regRst,
  input logic              cIn,
  input logic              cOut,
  input logic              wrDataF,
  input logic              wrDataG,
  input logic [ADDR_W-1:0] fIn,
  input clbStrobe_t        strobe,
  input logic [DEPTH-1:0]  tblF,
  input logic [DEPTH-1:0]  tblG,
  input logic              fQ,
  input logic              gQ
);
  // R10
  reg_clear_chk: assert property (@(posedge clk) disable iff (cfgEn)
    regRst |=> (fQ == 1'b0 && gQ == 1'b0));

  // R11
  reg_hold_chk: assert property (@(posedge clk) disable iff (cfgEn)
    (!regRst && !regCe) |=> ($stable(fQ) && $stable(gQ)));

  // R6
  table_stable_chk: assert property (@(posedge clk) disable iff (regRst)
    (!cfgEn && !(ramWe && strobe.isRam)) |=> ($stable(tblF) && $stable(tblG)));

  // R5
  ram_write_chk: assert property (@(posedge clk) disable iff (cfgEn)
    (strobe.isRam && ramWe) |=>
      (tblF[$past(fIn)] == $past(wrDataF) && tblG[$past(fIn)] == $past(wrDataG)));

  always_comb begin
    // R4
    if (!cfgEn && !strobe.isArith) begin
      carry_pass_chk: assert (cOut == cIn);
    end
    // R3
    if (!cfgEn && strobe.isArith && tblF[fIn]) begin
      carry_prop_chk: assert (cOut == cIn);
    end
    if (!cfgEn && strobe.isArith && !tblF[fIn]) begin
      carry_gen_chk: assert (cOut == tblG[fIn]);
    end
  end
endmodule

bind lut_clb clb_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk    (clk),
  .cfgEn  (cfgEn),
  .ramWe  (ramWe),
  .regCe  (regCe),
  .regRst (regRst),
  .cIn    (cIn),
  .cOut   (cOut),
  .wrDataF(wrDataF),
  .wrDataG(wrDataG),
  .fIn    (fIn),
  .strobe (strobe),
  .tblF   (tblF),
  .tblG   (tblG),
  .fQ     (fQ),
  .gQ     (gQ)
);

// File: tb/test_lut_clb.sv
module test_lut_clb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       cfgEn = 1'b0, cfgDin = 1'b0;
  logic [3:0] fIn = '0, gIn = '0;
  logic       eIn = 1'b0, cIn = 1'b0, cOut;
  logic       ramWe = 1'b0, wrDataF = 1'b0, wrDataG = 1'b0;
  logic       regCe = 1'b0, regRst = 1'b0;
  logic       fOut, gOut;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_clb i_lut_clb (
    .clk(clk), .cfgEn(cfgEn), .cfgDin(cfgDin), .fIn(fIn), .gIn(gIn), .eIn(eIn),
    .cIn(cIn), .cOut(cOut), .ramWe(ramWe), .wrDataF(wrDataF), .wrDataG(wrDataG),
    .regCe(regCe), .regRst(regRst), .fOut(fOut), .gOut(gOut)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // R7: 36-bit word, MSB first: mode, regEnF, regEnG, tableF, tableG
  task automatic loadCfg(input logic [1:0] m, input logic rf, input logic rg,
                         input logic [15:0] tf, input logic [15:0] tg, input logic holdWe);
    logic [35:0] word;
    word = {m, rf, rg, tf, tg};
    @(negedge clk);
    cfgEn = 1'b1; ramWe = holdWe; wrDataF = holdWe; wrDataG = holdWe;
    for (int i = 35; i >= 0; i--) begin
      cfgDin = word[i];
      @(negedge clk);
    end
    cfgEn = 1'b0; ramWe = 1'b0; wrDataF = 1'b0; wrDataG = 1'b0;
  endtask

  task automatic testRegisters();
    loadCfg(2'b00, 1'b1, 1'b1, 16'h0002, 16'h0002, 1'b0);
    fIn = 4'd1; gIn = 4'd1; regCe = 1'b1; regRst = 1'b1;
    @(posedge clk); #1;
    chk("R10 clear over enable fOut", fOut, 1'b0);
    chk("R10 clear over enable gOut", gOut, 1'b0);
    @(negedge clk); regRst = 1'b0;
    @(posedge clk); #1;
    chk("R9 captured fOut", fOut, 1'b1);
    chk("R9 captured gOut", gOut, 1'b1);
    @(negedge clk); fIn = 4'd0; #1;
    chk("R9 registered output ignores live input", fOut, 1'b1);
    @(posedge clk); #1;
    chk("R9 new capture fOut", fOut, 1'b0);
    @(negedge clk); regCe = 1'b0; fIn = 4'd1;
    @(posedge clk); #1;
    chk("R11 hold with enable low", fOut, 1'b0);
    chk("R11 hold gOut with enable low", gOut, 1'b1);
    @(negedge clk); regCe = 1'b1;
  endtask

  task automatic testDual();
    logic [15:0] tf = 16'h8000, tg = 16'h6996;
    loadCfg(2'b00, 1'b0, 1'b0, tf, tg, 1'b0);
    for (int v = 0; v < 16; v += 3) begin
      fIn = 4'(v); gIn = 4'(15 - v); cIn = v[0]; #1;
      chk("R1 dual fOut", fOut, tf[v]);
      chk("R1 dual gOut", gOut, tg[15 - v]);
      chk("R4 carry pass in dual", cOut, v[0]);
      @(negedge clk);
    end
    fIn = 4'd15; #1;
    chk("R7 load order table F top entry", fOut, 1'b1);
  endtask

  task automatic testWide();
    logic [15:0] tf = 16'hA5C3, tg = 16'h3CF0;
    loadCfg(2'b01, 1'b0, 1'b0, tf, tg, 1'b0);
    for (int v = 0; v < 16; v += 5) begin
      for (int e = 0; e < 2; e++) begin
        fIn = 4'(v); gIn = 4'(v + 1); eIn = e[0]; cIn = ~e[0]; #1;
        chk("R2 wide fOut", fOut, e[0] ? tg[v] : tf[v]);
        chk("R2 wide gOut low", gOut, 1'b0);
        chk("R4 carry pass in wide", cOut, ~e[0]);
        @(negedge clk);
      end
    end
    eIn = 1'b0;
  endtask

  task automatic testArith();
    logic p, k, c;
    loadCfg(2'b10, 1'b0, 1'b0, 16'h6666, 16'h8888, 1'b0);
    for (int a = 0; a < 4; a++) begin
      for (int ci = 0; ci < 2; ci++) begin
        fIn = 4'(a); cIn = ci[0]; #1;
        p = a[0] ^ a[1]; k = a[0] & a[1]; c = p ? ci[0] : k;
        chk("R3 arith sum", fOut, p ^ ci[0]);
        chk("R3 arith carry out", cOut, c);
        chk("R3 arith gOut carry", gOut, c);
        @(negedge clk);
      end
    end
    cIn = 1'b0;
  endtask

  task automatic testRam();
    // R8: load with writes of 1 requested during every shift
    loadCfg(2'b11, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1);
    for (int v = 0; v < 16; v++) begin
      fIn = 4'(v); #1;
      chk("R8 table F untouched during load", fOut, 1'b0);
      chk("R8 table G untouched during load", gOut, 1'b0);
    end
    @(negedge clk);
    fIn = 4'd3; ramWe = 1'b1; wrDataF = 1'b1; wrDataG = 1'b0; #1;
    chk("R5 read before write edge", fOut, 1'b0);
    @(posedge clk); #1;
    chk("R5 written F after edge", fOut, 1'b1);
    chk("R5 written G after edge", gOut, 1'b0);
    @(negedge clk);
    fIn = 4'd12; wrDataF = 1'b0; wrDataG = 1'b1;
    @(negedge clk);
    ramWe = 1'b0; fIn = 4'd3; #1;
    chk("R5 readback addr 3 F", fOut, 1'b1);
    chk("R5 readback addr 3 G", gOut, 1'b0);
    fIn = 4'd12; #1;
    chk("R5 readback addr 12 F", fOut, 1'b0);
    chk("R5 readback addr 12 G", gOut, 1'b1);
    fIn = 4'd7; #1;
    chk("R5 unwritten addr", fOut, 1'b0);
  endtask

  task automatic testWriteOutsideRam();
    loadCfg(2'b00, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0);
    fIn = 4'd5; gIn = 4'd5; ramWe = 1'b1; wrDataF = 1'b1; wrDataG = 1'b1;
    @(negedge clk); @(negedge clk);
    ramWe = 1'b0; #1;
    chk("R6 F unchanged in dual", fOut, 1'b0);
    chk("R6 G unchanged in dual", gOut, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testRegisters();
    testDual();
    testWide();
    testArith();
    testRam();
    testWriteOutsideRam();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule